// File: doc/BRIEF.md
# Byte-Serial Variable-Length Instruction Decoder

This block takes a stream of instruction bytes, one per clock, and turns each instruction of a 16-bit CISC encoding into a single decoded record. An instruction is one to six bytes long, and its length is only found out as the bytes arrive. The opcode tells the decoder whether a specifier byte follows. The mode and r/m fields of that specifier byte tell it how many displacement bytes come next. The opcode then tells it whether a 16-bit immediate closes the instruction.

The decoder accepts bytes through a valid/ready pair. Once reset is released it is always ready, because its per-byte work fits in one cycle. A decoded record is presented for one cycle, in the cycle after the last byte of an instruction is accepted. The byte that follows is treated as a fresh opcode. Opcodes outside the supported subset produce an error record and use up exactly one byte, so decoding lines up again on the next byte.

Top module: `ibyte_decoder`

## Requirements
- R1: While reset is asserted, in_ready and rec_valid are low. From the first clock after reset is released, in_ready is high.
- R2: Opcodes 0x50 to 0x57 are complete one-byte register pushes. The record has length 1, no error, rec_reg equal to opcode bits 2:0 (0 AX, 1 CX, 2 DX, 3 BX, 4 SP, 5 BP, 6 SI, 7 DI), rec_mode 11, rec_rm 0, and zero displacement and immediate.
- R3: Opcodes 0x01, 0x03, 0x89, 0x8B and 0x81 are followed by a specifier byte. The record reports its bits 7:6 as rec_mode, bits 5:3 as rec_reg and bits 2:0 as rec_rm.
- R4: The displacement follows the specifier byte directly. Its size depends on the mode: 11 has none, 01 has one byte, 10 has two bytes, and 00 has none except when r/m is 110, which takes a two-byte direct address.
- R5: A two-byte displacement arrives low byte first. A one-byte displacement is sign-extended to 16 bits. Absent fields read as zero.
- R6: Opcode 0x81 carries a 16-bit immediate after any displacement, low byte first, and its reg field is reported as the operation selector (7 = compare). For example, 81 FA CD AB gives reg 7, mode 11, rm 2, immediate 0xABCD, length 4, and 81 7E 08 CD AB gives mode 01, rm 6, displacement 0x0008, immediate 0xABCD, length 5.
- R7: rec_len equals the number of bytes the instruction used, from 1 to 6.
- R8: Any other opcode gives a record with rec_err high, length 1, the opcode echoed, and all other fields zero. The following byte is decoded as a new opcode.
- R9: rec_valid is high for exactly the cycle after the last byte of an instruction is accepted, and low in cycles after accepted non-final bytes.
- R10: Cycles with in_valid low are ignored, and the byte lines carry no meaning in them. Gaps between bytes of an instruction do not change the decoded result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A byte is offered on in_byte |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Decoder accepts the offered byte |
| rec_valid | output | 1 | Decoded record present this cycle |
| rec_err | output | 1 | Record is for an unsupported opcode |
| rec_opcode | output | 8 | First byte of the instruction |
| rec_mode | output | 2 | Specifier mode field (11 for pushes) |
| rec_reg | output | 3 | Specifier reg field, or push register |
| rec_rm | output | 3 | Specifier r/m field |
| rec_disp | output | 16 | Displacement, sign-extended when one byte |
| rec_imm | output | 16 | Immediate for opcode 0x81 |
| rec_len | output | 3 | Instruction length in bytes |

## Verification
The bench builds the decoder with its default parameters: 8-bit bytes, 2-byte fields and sign-extended short displacements. That configuration is small enough to sweep completely. Every one of the 256 opcodes is sent with a varying trailing byte pattern, which covers the push range, the specifier forms and the error path. Every one of the 256 specifier bytes is sent behind both a plain register/memory opcode and the immediate opcode, which covers each mode and r/m pairing, the direct-address case and displacements of both signs. These are mixed with back-to-back streaming and with stall gaps of different lengths.

// File: rtl/ibd_pkg.sv
`timescale 1ns/1ps
package ibd_pkg;

   // opcode families that steer the byte collection
   typedef enum logic [1:0] {
      OPC_BAD       = 2'd0,
      OPC_PUSH      = 2'd1,
      OPC_MODRM     = 2'd2,
      OPC_MODRM_IMM = 2'd3
   } opc_kind_t;

   // which byte of the instruction is expected next
   typedef enum logic [1:0] {
      ST_OPC  = 2'd0,
      ST_SPEC = 2'd1,
      ST_DISP = 2'd2,
      ST_IMM  = 2'd3
   } dec_state_t;

   localparam logic [1:0] MODE_REG_REG = 2'b11;
   localparam logic [2:0] RM_DIRECT    = 3'b110;
   localparam logic [7:0] OPC_GRP_IMM  = 8'h81;

endpackage

// File: rtl/ibd_op_class.sv
`timescale 1ns/1ps
module ibd_op_class
   import ibd_pkg::*;
(
   input  logic [7:0] op,
   output opc_kind_t  kind
);
   always_comb begin
      if (op inside {[8'h50:8'h57]}) begin
         kind = OPC_PUSH;
      end else begin
         unique case (op)
            8'h01, 8'h03, 8'h89, 8'h8B: kind = OPC_MODRM;
            OPC_GRP_IMM:                kind = OPC_MODRM_IMM;
            default:                    kind = OPC_BAD;
         endcase
      end
   end
endmodule

// File: rtl/ibd_disp_count.sv
`timescale 1ns/1ps
module ibd_disp_count
   import ibd_pkg::*;
#(
   parameter int CNT_W = 2
)(
   input  logic [1:0]       mode,
   input  logic [2:0]       rm,
   output logic [CNT_W-1:0] n
);
   always_comb begin
      unique case (mode)
         2'b01:   n = CNT_W'(1);
         2'b10:   n = CNT_W'(2);
         2'b00:   n = (rm == RM_DIRECT) ? CNT_W'(2) : CNT_W'(0);
         default: n = CNT_W'(0);
      endcase
   end
endmodule

// File: rtl/ibd_field_acc.sv
`timescale 1ns/1ps
module ibd_field_acc #(
   parameter int BYTE_W     = 8,
   parameter int NBYTES     = 2,
   parameter int IDX_W      = 2,
   parameter bit SEXT_FIRST = 1'b0,
   localparam int W         = BYTE_W * NBYTES
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [IDX_W-1:0]  idx,
   input  logic [BYTE_W-1:0] din,
   output logic [W-1:0]      val
);
   logic [W-1:0] first_ext;
   logic [W-1:0] nxt;

   generate
      if (SEXT_FIRST) begin : g_sext
         assign first_ext = {{(W-BYTE_W){din[BYTE_W-1]}}, din};
      end else begin : g_zext
         assign first_ext = {{(W-BYTE_W){1'b0}}, din};
      end
   endgenerate

   always_comb begin
      nxt = val;
      if (clr) begin
         nxt = '0;
      end else if (load) begin
         if (idx == '0) begin
            nxt = first_ext;
         end else begin
            for (int k = 1; k < NBYTES; k++) begin
               if (idx == IDX_W'(k)) nxt[k*BYTE_W +: BYTE_W] = din;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val <= '0;
      else        val <= nxt;
   end

   // R5: a loaded byte always lands inside the field
   a_r5_idx_in_field: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (int'(idx) < NBYTES));
endmodule

// File: rtl/ibyte_decoder.sv
`timescale 1ns/1ps
module ibyte_decoder
   import ibd_pkg::*;
#(
   parameter int  BYTE_W      = 8,
   parameter int  FIELD_BYTES = 2,
   parameter bit  SEXT_DISP8  = 1'b1,
   localparam int FIELD_W     = BYTE_W * FIELD_BYTES,
   localparam int MAX_LEN     = 2 + 2 * FIELD_BYTES,
   localparam int LEN_W       = $clog2(MAX_LEN + 1),
   localparam int CNT_W       = $clog2(FIELD_BYTES + 1)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [BYTE_W-1:0]  in_byte,
   output logic               in_ready,
   output logic               rec_valid,
   output logic               rec_err,
   output logic [7:0]         rec_opcode,
   output logic [1:0]         rec_mode,
   output logic [2:0]         rec_reg,
   output logic [2:0]         rec_rm,
   output logic [FIELD_W-1:0] rec_disp,
   output logic [FIELD_W-1:0] rec_imm,
   output logic [LEN_W-1:0]   rec_len
);
   generate
      if (BYTE_W != 8) begin : g_bad_byte_w
         $error("ibyte_decoder: the encoding needs BYTE_W of 8");
      end
      if (FIELD_BYTES != 2) begin : g_bad_field
         $error("ibyte_decoder: displacement and immediate fields are two bytes");
      end
   endgenerate

   dec_state_t       st_q;
   logic             ready_q, vld_q, err_q, imm_need_q;
   logic [7:0]       opc_q;
   logic [1:0]       mode_q;
   logic [2:0]       reg_q, rm_q;
   logic [LEN_W-1:0] len_q;
   logic [CNT_W-1:0] remain_q, idx_q;

   logic             acc, done_c;
   opc_kind_t        kind_c;
   logic [CNT_W-1:0] dcnt_c;

   assign acc = in_valid & ready_q;

   ibd_op_class u_cls (
      .op   (in_byte[7:0]),
      .kind (kind_c)
   );

   ibd_disp_count #(.CNT_W(CNT_W)) u_dcnt (
      .mode (in_byte[7:6]),
      .rm   (in_byte[2:0]),
      .n    (dcnt_c)
   );

   ibd_field_acc #(
      .BYTE_W(BYTE_W), .NBYTES(FIELD_BYTES), .IDX_W(CNT_W), .SEXT_FIRST(SEXT_DISP8)
   ) u_disp (
      .clk(clk), .rst_n(rst_n),
      .clr  (acc && st_q == ST_OPC),
      .load (acc && st_q == ST_DISP),
      .idx(idx_q), .din(in_byte), .val(rec_disp)
   );

   ibd_field_acc #(
      .BYTE_W(BYTE_W), .NBYTES(FIELD_BYTES), .IDX_W(CNT_W), .SEXT_FIRST(1'b0)
   ) u_imm (
      .clk(clk), .rst_n(rst_n),
      .clr  (acc && st_q == ST_OPC),
      .load (acc && st_q == ST_IMM),
      .idx(idx_q), .din(in_byte), .val(rec_imm)
   );

   // the accepted byte closes the instruction
   always_comb begin
      done_c = 1'b0;
      if (acc) begin
         unique case (st_q)
            ST_OPC:  done_c = (kind_c == OPC_PUSH) || (kind_c == OPC_BAD);
            ST_SPEC: done_c = (dcnt_c == '0) && !imm_need_q;
            ST_DISP: done_c = (remain_q == CNT_W'(1)) && !imm_need_q;
            ST_IMM:  done_c = (remain_q == CNT_W'(1));
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_OPC;
         ready_q    <= 1'b0;
         vld_q      <= 1'b0;
         err_q      <= 1'b0;
         imm_need_q <= 1'b0;
         opc_q      <= '0;
         mode_q     <= '0;
         reg_q      <= '0;
         rm_q       <= '0;
         len_q      <= '0;
         remain_q   <= '0;
         idx_q      <= '0;
      end else begin
         ready_q <= 1'b1;
         vld_q   <= done_c;
         if (acc) begin
            unique case (st_q)
               ST_OPC: begin
                  opc_q      <= in_byte[7:0];
                  mode_q     <= '0;
                  reg_q      <= '0;
                  rm_q       <= '0;
                  len_q      <= LEN_W'(1);
                  err_q      <= (kind_c == OPC_BAD);
                  imm_need_q <= (kind_c == OPC_MODRM_IMM);
                  if (kind_c == OPC_PUSH) begin
                     mode_q <= MODE_REG_REG;
                     reg_q  <= in_byte[2:0];
                  end
                  if (kind_c == OPC_MODRM || kind_c == OPC_MODRM_IMM) st_q <= ST_SPEC;
               end
               ST_SPEC: begin
                  mode_q <= in_byte[7:6];
                  reg_q  <= in_byte[5:3];
                  rm_q   <= in_byte[2:0];
                  len_q  <= len_q + LEN_W'(1);
                  idx_q  <= '0;
                  if (dcnt_c != '0) begin
                     st_q     <= ST_DISP;
                     remain_q <= dcnt_c;
                  end else if (imm_need_q) begin
                     st_q     <= ST_IMM;
                     remain_q <= CNT_W'(FIELD_BYTES);
                  end else begin
                     st_q <= ST_OPC;
                  end
               end
               ST_DISP: begin
                  len_q    <= len_q + LEN_W'(1);
                  idx_q    <= idx_q + CNT_W'(1);
                  remain_q <= remain_q - CNT_W'(1);
                  if (remain_q == CNT_W'(1)) begin
                     idx_q <= '0;
                     if (imm_need_q) begin
                        st_q     <= ST_IMM;
                        remain_q <= CNT_W'(FIELD_BYTES);
                     end else begin
                        st_q <= ST_OPC;
                     end
                  end
               end
               ST_IMM: begin
                  len_q    <= len_q + LEN_W'(1);
                  idx_q    <= idx_q + CNT_W'(1);
                  remain_q <= remain_q - CNT_W'(1);
                  if (remain_q == CNT_W'(1)) st_q <= ST_OPC;
               end
            endcase
         end
      end
   end

   assign in_ready   = ready_q;
   assign rec_valid  = vld_q;
   assign rec_err    = err_q;
   assign rec_opcode = opc_q;
   assign rec_mode   = mode_q;
   assign rec_reg    = reg_q;
   assign rec_rm     = rm_q;
   assign rec_len    = len_q;

   // R7: a reported length is always within one to the maximum
   a_r7_len_range: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> (rec_len >= LEN_W'(1) && rec_len <= LEN_W'(MAX_LEN)));

   // R9: a record only ever follows an accepted byte
   a_r9_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> $past(in_valid && in_ready));

   // R8: error records are single-byte with no specifier content
   a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_err) |-> (rec_len == LEN_W'(1) && rec_mode == 2'b00 && rec_imm == '0));

   // R2: push records are one byte and never flagged
   a_r2_push_len: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_opcode[7:3] == 5'b01010) |-> (rec_len == LEN_W'(1) && !rec_err));

   // R6: the immediate form is at least opcode, specifier and two immediate bytes
   a_r6_imm_len: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_opcode == OPC_GRP_IMM) |-> (rec_len >= LEN_W'(4)));

   // R4: register-register forms carry no displacement
   a_r4_regreg_len: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && !rec_err && rec_opcode[7:3] != 5'b01010 && rec_mode == MODE_REG_REG)
      |-> (rec_len == ((rec_opcode == OPC_GRP_IMM) ? LEN_W'(4) : LEN_W'(2))));

   // R10: the collection state holds while no byte is accepted
   a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_ready) |=> $stable(st_q));
endmodule

// File: tb/ibyte_decoder_tb.sv
`timescale 1ns/1ps
module ibyte_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [7:0]  in_byte;
   logic        in_ready, rec_valid, rec_err;
   logic [7:0]  rec_opcode;
   logic [1:0]  rec_mode;
   logic [2:0]  rec_reg, rec_rm, rec_len;
   logic [15:0] rec_disp, rec_imm;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   ibyte_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_ready(in_ready), .rec_valid(rec_valid), .rec_err(rec_err),
      .rec_opcode(rec_opcode), .rec_mode(rec_mode), .rec_reg(rec_reg),
      .rec_rm(rec_rm), .rec_disp(rec_disp), .rec_imm(rec_imm), .rec_len(rec_len)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // record layout: err, opcode, mode, reg, rm, disp, imm, len
   task automatic model(input logic [47:0] v, output int n, output logic [51:0] rec);
      logic [7:0]  b [6];
      logic [15:0] dsp, imm;
      int dl, il;
      for (int k = 0; k < 6; k++) b[k] = v[8*k +: 8];
      if (b[0][7:3] == 5'b01010) begin
         n   = 1;
         rec = {1'b0, b[0], 2'b11, b[0][2:0], 3'b000, 16'h0, 16'h0, 3'd1};
      end else if (b[0] inside {8'h01, 8'h03, 8'h89, 8'h8B, 8'h81}) begin
         case (b[1][7:6])
            2'b01:   dl = 1;
            2'b10:   dl = 2;
            2'b00:   dl = (b[1][2:0] == 3'b110) ? 2 : 0;
            default: dl = 0;
         endcase
         il  = (b[0] == 8'h81) ? 2 : 0;
         dsp = (dl == 1) ? {{8{b[2][7]}}, b[2]} : (dl == 2) ? {b[3], b[2]} : 16'h0;
         imm = (il == 2) ? {b[3+dl], b[2+dl]} : 16'h0;
         n   = 2 + dl + il;
         rec = {1'b0, b[0], b[1][7:6], b[1][5:3], b[1][2:0], dsp, imm, 3'(n)};
      end else begin
         n   = 1;
         rec = {1'b1, b[0], 2'b00, 3'b000, 3'b000, 16'h0, 16'h0, 3'd1};
      end
   endtask

   // entered just after a falling edge; returns just after a falling edge
   task automatic run_instr(input logic [47:0] v, input int gap, input string req);
      int n;
      logic [51:0] exp;
      model(v, n, exp);
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b1;
         in_byte  = v[8*i +: 8];
         @(posedge clk);
         @(negedge clk);
         in_valid = 1'b0;
         in_byte  = 8'h81;  // meaningless while in_valid is low
         if (i < n - 1) begin
            check("R9", "no record mid-instruction", 64'(rec_valid), 64'd0);
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               check("R10", "no record during stall", 64'(rec_valid), 64'd0);
            end
         end
      end
      check("R9", "record strobe", 64'(rec_valid), 64'd1);
      check(req, "record fields",
            64'({rec_err, rec_opcode, rec_mode, rec_reg, rec_rm, rec_disp, rec_imm, rec_len}),
            64'(exp));
      check("R7", "length", 64'(rec_len), 64'(exp[2:0]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL R9 watchdog: actual=hung expected=complete");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_byte  = 8'h00;
      repeat (3) @(negedge clk);
      check("R1", "ready in reset", 64'(in_ready), 64'd0);
      check("R1", "record in reset", 64'(rec_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "ready after reset", 64'(in_ready), 64'd1);
      check("R1", "no record after reset", 64'(rec_valid), 64'd0);

      // register compare with immediate
      run_instr(48'h0000_ABCD_FA81, 0, "R6");
      check("R6", "cmp reg imm", 64'({rec_reg, rec_mode, rec_rm, rec_imm}),
            64'({3'd7, 2'b11, 3'd2, 16'hABCD}));
      // memory compare with short displacement
      run_instr(48'h00AB_CD08_7E81, 1, "R6");
      check("R6", "cmp mem imm", 64'({rec_disp, rec_imm, rec_len}),
            64'({16'h0008, 16'hABCD, 3'd5}));
      // direct address form
      run_instr(48'h0000_1234_068B, 0, "R4");
      check("R4", "direct address", 64'({rec_disp, rec_len}), 64'({16'h1234, 3'd4}));
      // negative short displacement
      run_instr(48'h0000_00F0_4603, 2, "R5");
      check("R5", "sign extension", 64'(rec_disp), 64'h0000_0000_0000_FFF0);
      // push followed directly by an unsupported byte
      run_instr(48'h0000_0000_0055, 0, "R2");
      check("R2", "push BP reg", 64'(rec_reg), 64'd5);
      run_instr(48'h0000_0000_00F4, 0, "R8");
      check("R8", "error flag", 64'(rec_err), 64'd1);

      // every opcode
      for (int op = 0; op < 256; op++) begin
         logic [7:0] o;
         string req;
         o = 8'(op);
         if (o inside {[8'h50:8'h57]}) req = "R2";
         else if (o inside {8'h01, 8'h03, 8'h89, 8'h8B, 8'h81}) req = "R3";
         else req = "R8";
         run_instr({8'h3C, 8'hA7, 8'h96, 8'h85, o ^ 8'h5A, o}, op % 2, req);
      end

      // every specifier byte, displacement-only form
      for (int s = 0; s < 256; s++) begin
         logic [7:0] sb;
         sb = 8'(s);
         run_instr({8'h11, 8'h22, sb, sb ^ 8'hFF, sb, 8'h89}, 0, "R4");
      end

      // every specifier byte, immediate form with stalls
      for (int s = 0; s < 256; s++) begin
         logic [7:0] sb;
         sb = 8'(s);
         run_instr({8'h5E, 8'hC3, 8'h7A, sb ^ 8'h80, sb, 8'h81}, s % 3, "R6");
      end

      @(negedge clk);
      check("R9", "record drops when idle", 64'(rec_valid), 64'd0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule